// File: doc/BRIEF.md
# Iterative 32-bit Integer Divider

This block computes a quotient or a remainder from two operands, in signed or unsigned form. A caller raises `start` for one cycle with the operands and a two-bit operation code while the unit is idle. For ordinary operands a restoring shift-subtract datapath produces one quotient bit per cycle. After all bits are formed, one further cycle applies the sign fix-up, and then `done` pulses together with a valid `result`.

Signed division truncates toward zero. Two operand pairs never enter the iteration: a zero divisor, and the most negative value divided by minus one. Both give fixed results at once, with no trap and no busy period. While an operation runs, any new `start` is dropped.

Top module: `divu_top`

## Requirements
- R1: With op = 2'b01, `result` is the unsigned quotient of `dividend` by `divisor`, both read as unsigned magnitudes.
- R2: With op = 2'b11, `result` is the unsigned remainder of `dividend` by `divisor`.
- R3: With op = 2'b00, `result` is the signed quotient rounded toward zero.
- R4: With op = 2'b10, `result` is the signed remainder, which takes the sign of the dividend (or is zero).
- R5: A zero divisor gives a quotient with every bit set, for both quotient codes.
- R6: A zero divisor gives a remainder equal to the dividend, for both remainder codes.
- R7: For a signed code with dividend 32'h8000_0000 and divisor 32'hFFFF_FFFF, the quotient is 32'h8000_0000 and the remainder is zero.
- R8: For the cases in R5 to R7, `done` is high in the cycle right after the edge that accepts `start`, and `busy` stays low.
- R9: For any other operands, `busy` is high from the accepting edge onward, and `done` goes high after the 34th rising edge, counting the accepting edge as the first.
- R10: `done` is high for exactly one cycle per accepted operation.
- R11: A `start` while `busy` is high is ignored: it produces no extra `done`, and the running result and its timing do not change.
- R12: While reset is held, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| start | input | 1 | Requests an operation; accepted only when idle |
| op | input | 2 | bit0 = unsigned, bit1 = remainder |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Iteration or fix-up in progress |
| done | output | 1 | One-cycle pulse marking `result` valid |
| result | output | 32 | Quotient or remainder |

## Verification
The properties assume that `op`, `dividend` and `divisor` are stable on the edge where `start` is accepted. The special-case properties compare the result against the operands of that edge. They also assume that reset is released away from a clock edge. The stimulus drives every input on the falling edge and holds the operands while `start` is high. It sends a stray `start` only while `busy` is already high, which is where the design must ignore it.

// File: rtl/divu_pkg.sv
package divu_pkg;
  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } div_st_e;
endpackage

// File: rtl/divu_prep.sv
module divu_prep #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] mag_dvd,
  output logic [W-1:0] mag_dvs,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         special,
  output logic [W-1:0] special_res
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic is_signed, dvd_neg, dvs_neg, by_zero, ovf;

  always_comb begin
    is_signed   = ~op[0];
    dvd_neg     = is_signed & dvd[W-1];
    dvs_neg     = is_signed & dvs[W-1];
    mag_dvd     = dvd_neg ? (~dvd + 1'b1) : dvd;
    mag_dvs     = dvs_neg ? (~dvs + 1'b1) : dvs;
    neg_quo     = dvd_neg ^ dvs_neg;
    neg_rem     = dvd_neg;
    by_zero     = (dvs == '0);
    ovf         = is_signed & (dvd == MOST_NEG) & (&dvs);
    special     = by_zero | ovf;
    if (by_zero) special_res = op[1] ? dvd : '1;
    else         special_res = op[1] ? '0  : MOST_NEG;
  end
endmodule

// File: rtl/divu_step.sv
module divu_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         fits;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs_i};
    fits    = ~diff[W+1];
    rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/divu_fix.sv
module divu_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic         want_rem,
  output logic [W-1:0] res
);
  always_comb begin
    if (want_rem) res = neg_rem ? (~rem + 1'b1) : rem;
    else          res = neg_quo ? (~quo + 1'b1) : quo;
  end
endmodule

// File: rtl/divu_top.sv
module divu_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  import divu_pkg::*;

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic          nq_q, nq_d, nr_q, nr_d, sel_q, sel_d;
  logic [W-1:0]  res_q, res_d;
  logic          done_q, done_d;
  logic          en_dp, en_res;

  logic [W-1:0]  mag_dvd, mag_dvs, spec_res, step_rem, step_quo, fix_res;
  logic          neg_quo, neg_rem, special, accept;

  divu_prep #(.W(W)) u_prep (
    .op(op), .dvd(dividend), .dvs(divisor),
    .mag_dvd(mag_dvd), .mag_dvs(mag_dvs),
    .neg_quo(neg_quo), .neg_rem(neg_rem),
    .special(special), .special_res(spec_res)
  );

  divu_step #(.W(W)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .dvs_i(dvs_q),
    .rem_o(step_rem), .quo_o(step_quo)
  );

  divu_fix #(.W(W)) u_fix (
    .rem(rem_q), .quo(quo_q), .neg_quo(nq_q), .neg_rem(nr_q),
    .want_rem(sel_q), .res(fix_res)
  );

  assign accept = start & (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    nq_d   = nq_q;
    nr_d   = nr_q;
    sel_d  = sel_q;
    res_d  = res_q;
    done_d = 1'b0;
    en_dp  = 1'b0;
    en_res = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (special) begin
          res_d  = spec_res;
          done_d = 1'b1;
          en_res = 1'b1;
        end else begin
          st_d  = ST_ITER;
          cnt_d = '0;
          rem_d = '0;
          quo_d = mag_dvd;
          dvs_d = mag_dvs;
          nq_d  = neg_quo;
          nr_d  = neg_rem;
          sel_d = op[1];
          en_dp = 1'b1;
        end
      end
      ST_ITER: begin
        rem_d = step_rem;
        quo_d = step_quo;
        cnt_d = cnt_q + 1'b1;
        en_dp = 1'b1;
        if (cnt_q == LAST) st_d = ST_FIX;
      end
      ST_FIX: begin
        res_d  = fix_res;
        done_d = 1'b1;
        en_res = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      nq_q  <= 1'b0;
      nr_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (en_dp) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      nq_q  <= nq_d;
      nr_q  <= nr_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (en_res) res_q <= res_d;
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/divu_chk.sv
module divu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  AST_ZERO_QUO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0 && !op[1]) |=> (done && result == '1)); // R5
  AST_ZERO_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0 && op[1]) |=> (done && result == $past(dividend))); // R6
  AST_OVF_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[0] && dividend == MOST_NEG && (&divisor))
      |=> (done && result == (op[1] ? '0 : MOST_NEG))); // R7
  AST_SPECIAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (divisor == '0 || (!op[0] && dividend == MOST_NEG && (&divisor))))
      |=> !busy); // R8
  AST_GENERAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0 && !(!op[0] && dividend == MOST_NEG && (&divisor)))
      |=> (busy && !done)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && start) |=> (busy || done)); // R11
endmodule

bind divu_top divu_chk #(.W(W)) u_chk (.*);

// File: tb/divu_top_bench.sv
`timescale 1ns/1ps
module divu_top_bench;
  localparam int W = 32;
  localparam logic [W-1:0] MN = 32'h8000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   op;
  logic [W-1:0] dividend, divisor;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] val;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  divu_top #(.W(W)) u_divu_top (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [W-1:0] model(input logic [1:0] o, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    if (b == '0) return o[1] ? a : '1;
    if (o[0]) return o[1] ? (a % b) : (a / b);
    if (a == MN && b == '1) return o[1] ? '0 : MN;
    return o[1] ? W'($signed(a) % $signed(b)) : W'($signed(a) / $signed(b));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10/R11 unexpected done", result, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result === e.val, e.tag, result, e.val);
      end
    end
  end

  // Driver: pushes expectation, issues the request, checks timing
  task automatic run(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                     input string tag, input bit intrude);
    bit spec;
    int n;
    exp_t e;
    spec = (b == '0) || (!o[0] && a == MN && b == '1);
    e.val = model(o, a, b);
    e.tag = tag;
    while (busy) @(negedge clk);
    sb.push_back(e);
    op = o; dividend = a; divisor = b; start = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
      if (spec && n == 1) chk(!busy, "R8 busy low", {31'b0, busy}, '0);
      if (!spec && n == 10) chk(busy, "R9 busy high", {31'b0, busy}, 1);
      if (intrude && n == 5) begin
        op = 2'b00; dividend = 32'd5; divisor = '0; start = 1'b1;
      end
      if (intrude && n == 6) start = 1'b0;
      if (done || n > 60) break;
    end
    chk(n == (spec ? 1 : 34), spec ? "R8 latency" : "R9 latency", n, spec ? 1 : 34);
    @(negedge clk);
    chk(!done, "R10 single pulse", {31'b0, done}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R12 reset idle", {30'b0, busy, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run(2'b01, 32'd100, 32'd7, "R1 divu", 0);
    run(2'b01, 32'hFFFF_FFFF, 32'd3, "R1 divu big", 0);
    run(2'b01, MN, 32'hFFFF_FFFF, "R1 divu not overflow", 0);
    run(2'b11, 32'd100, 32'd7, "R2 remu", 0);
    run(2'b11, 32'hFFFF_FFF0, 32'h1234, "R2 remu big", 0);
    run(2'b00, -32'sd7, 32'd2, "R3 div trunc", 0);
    run(2'b00, -32'sd7, -32'sd2, "R3 div negneg", 0);
    run(2'b00, 32'd1000, -32'sd33, "R3 div posneg", 0);
    run(2'b10, -32'sd7, 32'd2, "R4 rem negdvd", 0);
    run(2'b10, 32'd7, -32'sd2, "R4 rem posdvd", 0);
    run(2'b10, MN, 32'd3, "R4 rem mostneg", 0);
    run(2'b00, 32'd42, '0, "R5 div by zero", 0);
    run(2'b01, 32'd42, '0, "R5 divu by zero", 0);
    run(2'b10, -32'sd9, '0, "R6 rem by zero", 0);
    run(2'b11, 32'hDEAD_BEEF, '0, "R6 remu by zero", 0);
    run(2'b00, MN, 32'hFFFF_FFFF, "R7 overflow quo", 0);
    run(2'b10, MN, 32'hFFFF_FFFF, "R7 overflow rem", 0);
    run(2'b01, 32'd999, 32'd10, "R11 start while busy", 1);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R11 queue drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule